// File: doc/BRIEF.md
# Display Drive Protection Monitor

This block supervises the safety-related status of a cathode-ray-tube display back end and produces two enables for it. The first is a request to blank the RGB drive. The second is a shutoff for the horizontal drive. It combines three conditions.

- **Flyback watchdog.** A field without a falling edge on the vertical flyback pulse blanks the RGB drive. The blank holds until a field with such an edge has been completed.
- **Flyback-interval blanking.** Software can enable blanking of the RGB drive while the flyback pulse is high.
- **Safety level decoder.** A safety level arrives as two comparator outputs, one for a lower threshold and one for a higher threshold. Each comparator output is synchronised. The decoder then keeps the decoded zone unchanged until the new level has held for a programmable number of clocks. This dwell filter stands in for the comparators' hysteresis, so the zone does not chatter at a boundary.

A sticky status register records each protection condition that has fired. Software clears a bit by writing 1 to it. The comparators, the video path and the deflection waveforms are outside the block.

Top module: `disp_prot_mon`

## Requirements
- R1: After reset, rgb_blank_o and hdrv_off_o are 0, status_o is 0 and zone_o is 0 (normal).
- R2: The zone decode and its outputs are as follows, with zone_o encoded 0 = normal, 1 = RGB blank, 2 = shutdown:
  - Neither comparator asserted gives zone 0, with no blanking from the zone.
  - cmp_lo_i alone gives zone 1: rgb_blank_o is 1 and hdrv_off_o is 0.
  - cmp_hi_i asserted, with or without cmp_lo_i, gives zone 2: rgb_blank_o and hdrv_off_o are both 1.
- R3: A change of the comparator inputs is counted from the first clock edge that sees the new value after the 2-flop synchroniser. The decoded zone takes the new value only once that value has held for max(dwell_i,1) consecutive clock edges. Its outputs therefore change after edge 2+max(dwell_i,1), counted from the first edge that samples the new input.
- R4: A comparator excursion shorter than the dwell leaves zone_o, rgb_blank_o and hdrv_off_o unchanged.
- R5: When fly_blank_en_i is 1, rgb_blank_o is 1 in every cycle in which vfly_i is 1, with no register delay. When fly_blank_en_i is 0, vfly_i has no effect on rgb_blank_o.
- R6: A field_start_i strobe sets the flyback-missing condition at that clock edge if vfly_i has shown no falling edge since the previous strobe or since reset. A falling edge on the strobe's own cycle counts as seen. Once set, the condition drives rgb_blank_o to 1.
- R7: The flyback-missing condition is released at the first strobe that closes a field in which a falling edge of vfly_i was seen.
- R8: status_o records conditions as sticky bits: bit 0 = flyback missing, bit 1 = zone at or above 1, bit 2 = zone 2. A bit is set at the clock edge after its condition is present, and it stays set until cleared.
- R9: Writing 1 to a bit of sts_clr_i clears that status bit at the next edge, but only if its condition is not active. The other bits are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vfly_i | input | 1 | Vertical flyback pulse, synchronous to clk |
| field_start_i | input | 1 | One-cycle strobe at the start of each field |
| fly_blank_en_i | input | 1 | Software enable for blanking during flyback |
| cmp_lo_i | input | 1 | Lower-threshold comparator output, asynchronous |
| cmp_hi_i | input | 1 | Higher-threshold comparator output, asynchronous |
| dwell_i | input | DWELL_W | Clocks a new zone must hold (0 acts as 1) |
| sts_clr_i | input | 3 | Write-1-to-clear pulses for the status bits |
| rgb_blank_o | output | 1 | RGB drive blank request |
| hdrv_off_o | output | 1 | Horizontal drive shutoff |
| zone_o | output | 2 | Decoded safety zone |
| status_o | output | 3 | Sticky protection status |

## Verification
The results are due at different times after a stimulus, and every check samples at the falling clock edge that follows the rising edge on which its result is due.

| Stimulus | Result | When it is due |
|---|---|---|
| Comparator change | Zone and its outputs | After rising edge 2+max(dwell_i,1). A check one edge earlier confirms that nothing has moved yet. |
| field_start_i strobe | Flyback-missing blank | After the edge that samples the strobe |
| Any protection condition | Matching status bit | One edge after its condition |
| vfly_i with fly_blank_en_i set | Flyback-interval blank | Combinational, so it is checked in the same cycle as it is driven |

Chatter is checked with excursions of two cycles against a dwell of four.

// File: rtl/disp_prot_pkg.sv
package disp_prot_pkg;

    typedef enum logic [1:0] {
        ZN_NORMAL = 2'd0,
        ZN_BLANK  = 2'd1,
        ZN_SHUT   = 2'd2
    } zone_e;

    localparam int STS_W     = 3;
    localparam int STS_MISS  = 0;
    localparam int STS_BLANK = 1;
    localparam int STS_SHUT  = 2;

    typedef struct packed {
        logic shut;
        logic blank;
        logic miss;
    } prot_cond_t;

    function automatic zone_e decode_zone(input logic lo, input logic hi);
        if (hi)      return ZN_SHUT;
        else if (lo) return ZN_BLANK;
        else         return ZN_NORMAL;
    endfunction

endpackage

// File: rtl/dpm_sync2.sv
module dpm_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d_i[g];
                s2_q <= s1_q;
            end
        end
        assign q_o[g] = s2_q;
    end
endmodule

// File: rtl/dpm_zone_filter.sv
module dpm_zone_filter
    import disp_prot_pkg::*;
#(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  zone_e              raw_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output zone_e              zone_o
);
    zone_e              zone_q, cand_q;
    logic [DWELL_W-1:0] cnt_q;
    logic [DWELL_W-1:0] dwell_eff;
    logic [DWELL_W:0]   cnt_next;

    assign dwell_eff = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
    assign cnt_next  = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            zone_q <= ZN_NORMAL;
            cand_q <= ZN_NORMAL;
            cnt_q  <= '0;
        end else if (raw_i == zone_q) begin
            cand_q <= raw_i;
            cnt_q  <= '0;
        end else if (raw_i != cand_q) begin
            cand_q <= raw_i;
            if (dwell_eff == DWELL_W'(1)) begin
                zone_q <= raw_i;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= DWELL_W'(1);
            end
        end else if (cnt_next >= {1'b0, dwell_eff}) begin
            zone_q <= raw_i;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_next[DWELL_W-1:0];
        end
    end

    assign zone_o = zone_q;
endmodule

// File: rtl/dpm_fly_watchdog.sv
module dpm_fly_watchdog (
    input  logic clk,
    input  logic rst,
    input  logic vfly_i,
    input  logic field_start_i,
    output logic missing_o
);
    logic vfly_q, seen_q, miss_q, fall;

    assign fall = vfly_q & ~vfly_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            vfly_q <= 1'b0;
            seen_q <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            vfly_q <= vfly_i;
            if (field_start_i) begin
                miss_q <= ~(seen_q | fall);
                seen_q <= 1'b0;
            end else if (fall) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign missing_o = miss_q;
endmodule

// File: rtl/dpm_status_reg.sv
module dpm_status_reg
    import disp_prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  prot_cond_t       cond_i,
    input  logic [STS_W-1:0] clr_i,
    output logic [STS_W-1:0] status_o
);
    logic [STS_W-1:0] sts_q;

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (sts_q & ~clr_i) | cond_i;
    end

    assign status_o = sts_q;
endmodule

// File: rtl/disp_prot_mon.sv
module disp_prot_mon
    import disp_prot_pkg::*;
#(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vfly_i,
    input  logic               field_start_i,
    input  logic               fly_blank_en_i,
    input  logic               cmp_lo_i,
    input  logic               cmp_hi_i,
    input  logic [DWELL_W-1:0] dwell_i,
    input  logic [2:0]         sts_clr_i,
    output logic               rgb_blank_o,
    output logic               hdrv_off_o,
    output logic [1:0]         zone_o,
    output logic [2:0]         status_o
);
    logic [1:0] cmp_s;
    zone_e      raw_zone, zone;
    logic       fly_miss;
    prot_cond_t cond;

    dpm_sync2 #(.WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cmp_hi_i, cmp_lo_i}),
        .q_o (cmp_s)
    );

    assign raw_zone = decode_zone(cmp_s[0], cmp_s[1]);

    dpm_zone_filter #(.DWELL_W(DWELL_W)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (raw_zone),
        .dwell_i (dwell_i),
        .zone_o  (zone)
    );

    dpm_fly_watchdog u_wdog (
        .clk           (clk),
        .rst           (rst),
        .vfly_i        (vfly_i),
        .field_start_i (field_start_i),
        .missing_o     (fly_miss)
    );

    always_comb begin
        cond.miss  = fly_miss;
        cond.blank = (zone != ZN_NORMAL);
        cond.shut  = (zone == ZN_SHUT);
    end

    dpm_status_reg u_sts (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (cond),
        .clr_i    (sts_clr_i),
        .status_o (status_o)
    );

    assign rgb_blank_o = fly_miss | (fly_blank_en_i & vfly_i) | cond.blank;
    assign hdrv_off_o  = cond.shut;
    assign zone_o      = zone;
endmodule

// File: rtl/disp_prot_mon_chk.sv
module disp_prot_mon_chk
    import disp_prot_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       vfly_i,
    input logic       fly_blank_en_i,
    input logic       cmp_lo_i,
    input logic       cmp_hi_i,
    input logic [2:0] sts_clr_i,
    input logic       rgb_blank_o,
    input logic       hdrv_off_o,
    input logic [1:0] zone_o,
    input logic [2:0] status_o
);
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)             age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    AST_HOFF_IMPLIES_BLANK: assert property (@(posedge clk) disable iff (rst)
        hdrv_off_o |-> rgb_blank_o);                                   // R2
    AST_NORMAL_NO_HOFF: assert property (@(posedge clk) disable iff (rst)
        (zone_o == 2'd0) |-> !hdrv_off_o);                             // R2
    AST_ZONE_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd5 && !$stable(zone_o)) |->
        (zone_o == 2'(decode_zone($past(cmp_lo_i, 3), $past(cmp_hi_i, 3))))); // R3
    AST_FLY_BLANK: assert property (@(posedge clk) disable iff (rst)
        (fly_blank_en_i && vfly_i) |-> rgb_blank_o);                   // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_o & ~sts_clr_i) != 3'd0 |=>
        ((status_o & $past(status_o & ~sts_clr_i)) == $past(status_o & ~sts_clr_i))); // R8
endmodule

bind disp_prot_mon disp_prot_mon_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .vfly_i         (vfly_i),
    .fly_blank_en_i (fly_blank_en_i),
    .cmp_lo_i       (cmp_lo_i),
    .cmp_hi_i       (cmp_hi_i),
    .sts_clr_i      (sts_clr_i),
    .rgb_blank_o    (rgb_blank_o),
    .hdrv_off_o     (hdrv_off_o),
    .zone_o         (zone_o),
    .status_o       (status_o)
);

// File: tb/disp_prot_mon_bench.sv
`timescale 1ns/1ps
module disp_prot_mon_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vfly = 1'b0, fstart = 1'b0, en = 1'b0, lo = 1'b0, hi = 1'b0;
    logic [DW-1:0] dwell = 8'd2;
    logic [2:0]    clr = 3'd0;
    logic          blank, hoff;
    logic [1:0]    zone;
    logic [2:0]    sts;
    int            n_run = 0, n_fail = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    disp_prot_mon #(.DWELL_W(DW)) u_disp_prot_mon (
        .clk(clk), .rst(rst), .vfly_i(vfly), .field_start_i(fstart),
        .fly_blank_en_i(en), .cmp_lo_i(lo), .cmp_hi_i(hi), .dwell_i(dwell),
        .sts_clr_i(clr), .rgb_blank_o(blank), .hdrv_off_o(hoff),
        .zone_o(zone), .status_o(sts)
    );

    // {lo, hi, en, vfly, exp_blank, exp_hoff}
    localparam logic [5:0] VEC [9] = '{
        6'b0000_00, 6'b0010_00, 6'b0011_10, 6'b0001_00, 6'b1000_10,
        6'b1011_10, 6'b1100_11, 6'b0100_11, 6'b0000_00
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe();
        fstart = 1'b1;
        tick(1);
        fstart = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        chk("R1 blank", {3'd0, blank}, 4'd0);
        chk("R1 hoff", {3'd0, hoff}, 4'd0);
        chk("R1 zone", {2'd0, zone}, 4'd0);
        chk("R1 status", {1'b0, sts}, 4'd0);

        // R2/R5: vector table, dwell 2, settle 2+2 edges plus margin
        for (int i = 0; i < 9; i++) begin
            lo = VEC[i][5]; hi = VEC[i][4]; en = VEC[i][3]; vfly = VEC[i][2];
            tick(5);
            chk("R2/R5 blank", {3'd0, blank}, {3'd0, VEC[i][1]});
            chk("R2 hoff", {3'd0, hoff}, {3'd0, VEC[i][0]});
        end
        en = 1'b0; vfly = 1'b0;
        clr = 3'b111; tick(1); clr = 3'd0;
        chk("R9 clear all", {1'b0, sts}, 4'd0);

        // R5: enable off, vfly has no effect
        vfly = 1'b1; #1;
        chk("R5 disabled", {3'd0, blank}, 4'd0);
        vfly = 1'b0;
        tick(1);

        // R6/R7: first strobe after a seen edge, then an empty field
        strobe();
        chk("R7 seen field", {3'd0, blank}, 4'd0);
        tick(3);
        strobe();
        chk("R6 missing blank", {3'd0, blank}, 4'd1);
        chk("R8 status lag", {3'd0, sts[0]}, 4'd0);
        tick(1);
        chk("R8 miss status", {3'd0, sts[0]}, 4'd1);
        clr = 3'b001; tick(1); clr = 3'd0;
        chk("R9 clear while active", {3'd0, sts[0]}, 4'd1);
        strobe();
        chk("R6 still missing", {3'd0, blank}, 4'd1);
        vfly = 1'b1; tick(2); vfly = 1'b0; tick(2);
        strobe();
        chk("R7 released", {3'd0, blank}, 4'd0);
        clr = 3'b001; tick(1); clr = 3'd0;
        chk("R9 cleared bit0", {1'b0, sts}, 4'd0);

        // R3: dwell 4, new input sampled at first edge, due after edge 6
        dwell = 8'd4;
        lo = 1'b1;
        tick(5);
        chk("R3 not yet", {2'd0, zone}, 4'd0);
        tick(1);
        chk("R3 zone blank", {2'd0, zone}, 4'd1);
        chk("R3 blank out", {3'd0, blank}, 4'd1);
        tick(1);
        chk("R8 blank status", {1'b0, sts}, 4'b0010);

        // R4: two-cycle excursions never reach the dwell
        for (int k = 0; k < 4; k++) begin
            lo = 1'b0; tick(2);
            lo = 1'b1; tick(2);
        end
        tick(6);
        chk("R4 zone held", {2'd0, zone}, 4'd1);
        hi = 1'b1; tick(1); hi = 1'b0;
        tick(8);
        chk("R4 hoff held", {3'd0, hoff}, 4'd0);

        // R2/R8/R9: shutdown zone, selective clear
        hi = 1'b1;
        tick(7);
        chk("R2 shutdown", {3'd0, hoff}, 4'd1);
        clr = 3'b110; tick(1); clr = 3'd0;
        chk("R9 clr blocked", {1'b0, sts}, 4'b0110);
        lo = 1'b0; hi = 1'b0;
        tick(6);
        chk("R2 back normal", {2'd0, zone}, 4'd0);
        clr = 3'b100; tick(1); clr = 3'd0;
        chk("R9 only bit2", {1'b0, sts}, 4'b0010);

        // R3: dwell 0 acts as 1, due after edge 3
        dwell = 8'd0;
        lo = 1'b1;
        tick(2);
        chk("R3 dwell0 not yet", {2'd0, zone}, 4'd0);
        tick(1);
        chk("R3 dwell0 zone", {2'd0, zone}, 4'd1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule